// File: doc/BRIEF.md
# ADC Sample and Conversion Sequencer

This block is the digital side of a successive-approximation converter. It runs on one system clock and builds a slower conversion clock from four clock-enable inputs. A 2-bit field picks one of the enables. A 3-bit field then divides that stream by an integer from 1 to 8, and every divided enable is one conversion tick.

A second 2-bit field picks the sample trigger. The choices are a software start bit and three timer outputs. The chosen trigger can be inverted, and it is re-registered on conversion ticks before it is used.

Once the block is powered and armed, a rising trigger starts sampling. In direct mode the sample signal follows the synchronised trigger. In pulse mode the trigger only starts a timer, and that timer holds the sample signal high for a programmed number of ticks. When the sample signal falls, a 13-tick conversion window begins:

- Twelve ticks resolve the result one bit per tick, from MSB to LSB, using the comparator input. The current trial word is presented to the external DAC.
- The thirteenth tick loads the result register and raises a one-cycle done pulse.

Top module: `adc_seq`

## Requirements
- R1: The conversion tick comes from the clock enable picked by `clk_sel` (value n selects `clk_en[n]`), divided by `div_sel`+1. Every tick-based duration is scaled by exactly that factor.
- R2: `trig_sel` picks the trigger: 0 selects `sw_start`, and 1, 2, 3 select `tmr_trig[0]`, `tmr_trig[1]`, `tmr_trig[2]`. Unselected trigger inputs have no effect.
- R3: When `trig_inv` is 1, the selected trigger is inverted before use, so a falling input starts sampling.
- R4: In direct mode (`pulse_mode`=0), `samp` goes high two ticks after the trigger rises and low two ticks after it falls. Its high time therefore equals the trigger's high time.
- R5: In pulse mode, `samp` stays high for 4<<`samp_code` ticks, and codes 8 and above give 1024 ticks.
- R6: A conversion starts on the tick where `samp` falls, with the trial word 0x800, and lasts exactly 13 ticks up to the done pulse.
- R7: The result is resolved MSB first. Each bit keeps `comp` as sampled with that bit set in `trial`, so a comparator meaning "input >= trial" yields the input value.
- R8: `done` is high for exactly one clock, in the cycle where `result` takes its new value. `result` is unchanged at all other times.
- R9: `busy` is high from the start of sampling until the done pulse, and low whenever `done` is high.
- R10: A trigger edge that occurs while `busy` is high starts nothing, either during or after the current conversion.
- R11: No trigger starts sampling while `arm` is 0. While `pwr` is 0 the block stays idle, and clearing it in the middle of a conversion aborts that conversion with no done pulse.
- R12: After reset, `samp`, `busy`, `done`, `trial` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr | input | 1 | Master power-on; 0 holds the block idle |
| arm | input | 1 | Allows a trigger to start sampling |
| pulse_mode | input | 1 | 1: sampling timer, 0: trigger drives sample signal |
| clk_sel | input | 2 | Clock-enable source select |
| div_sel | input | 3 | Divide ratio minus one |
| trig_sel | input | 2 | Trigger source select |
| trig_inv | input | 1 | Invert selected trigger |
| samp_code | input | 4 | Sampling-time code for pulse mode |
| clk_en | input | 4 | Clock-enable sources |
| sw_start | input | 1 | Software start trigger |
| tmr_trig | input | 3 | Timer trigger inputs |
| comp | input | 1 | Comparator: analog input >= trial word |
| samp | output | 1 | Sample-and-hold control, high = sample |
| busy | output | 1 | Sampling or converting |
| trial | output | 12 | Trial word for the DAC |
| result | output | 12 | Last conversion result |
| done | output | 1 | One-cycle conversion-complete pulse |

## Verification
The trigger needs two ticks to reach `samp`: one to register it and one to detect the edge. `samp` then stays high for its programmed tick count. `done` and the fall of `busy` both arrive 13 ticks after `samp` falls.

The bench never predicts absolute edge times. It samples on falling clock edges and counts the cycles `samp` is high and the cycles `busy` is high while `samp` is low. It then compares those counts with ticks × enable period × divide ratio, and reads `done` and `result` on the falling edge right after `busy` drops. In the direct-mode and abort tests it uses an undivided, always-on clock enable, so every tick is one clock and fixed cycle offsets hold exactly.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int RES   = 12,
  parameter int DIVW  = 3,
  parameter int CODEW = 4,
  parameter int TMRW  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr,
  input  logic             arm,
  input  logic             pulse_mode,
  input  logic [1:0]       clk_sel,
  input  logic [DIVW-1:0]  div_sel,
  input  logic [1:0]       trig_sel,
  input  logic             trig_inv,
  input  logic [CODEW-1:0] samp_code,
  input  logic [3:0]       clk_en,
  input  logic             sw_start,
  input  logic [2:0]       tmr_trig,
  input  logic             comp,
  output logic             samp,
  output logic             busy,
  output logic [RES-1:0]   trial,
  output logic [RES-1:0]   result,
  output logic             done
);
  typedef enum logic [1:0] {IDLE, SAMPLE, CONV} st_t;
  localparam logic [RES-1:0] TOP = {1'b1, {(RES-1){1'b0}}};

  st_t             st;
  logic [DIVW-1:0] dcnt;
  logic [TMRW-1:0] tmr, len_m1;
  logic [RES-1:0]  sar, ptr;
  logic [3:0]      trig_vec;
  logic            src_en, tick, trig_raw, trig_s, trig_q, samp_end;

  assign src_en   = clk_en[clk_sel];
  assign tick     = pwr && src_en && (dcnt == div_sel);
  assign trig_vec = {tmr_trig, sw_start};
  assign trig_raw = trig_vec[trig_sel] ^ trig_inv;
  assign len_m1   = (samp_code >= CODEW'(TMRW - 2)) ? '1
                  : TMRW'((32'd4 << samp_code) - 32'd1);
  assign samp_end = pulse_mode ? (tmr == '0) : !trig_s;

  assign samp  = (st == SAMPLE);
  assign busy  = (st != IDLE);
  assign trial = sar;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dcnt <= '0;
    else if (!pwr)
      dcnt <= '0;
    else if (src_en)
      dcnt <= (dcnt == div_sel) ? '0 : dcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      trig_s <= 1'b0;
      trig_q <= 1'b0;
      tmr    <= '0;
      sar    <= '0;
      ptr    <= '0;
      result <= '0;
      done   <= 1'b0;
    end else if (!pwr) begin
      st     <= IDLE;
      trig_s <= 1'b0;
      trig_q <= 1'b0;
      tmr    <= '0;
      ptr    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        trig_s <= trig_raw;
        trig_q <= trig_s;
        case (st)
          IDLE: begin
            if (arm && trig_s && !trig_q) begin
              st  <= SAMPLE;
              tmr <= len_m1;
            end
          end
          SAMPLE: begin
            if (samp_end) begin
              st  <= CONV;
              sar <= TOP;
              ptr <= TOP;
            end else if (tmr != '0) begin
              tmr <= tmr - 1'b1;
            end
          end
          CONV: begin
            if (ptr == '0) begin
              result <= sar;
              done   <= 1'b1;
              st     <= IDLE;
            end else begin
              sar <= (sar & ~ptr) | (comp ? ptr : '0) | (ptr >> 1);
              ptr <= ptr >> 1;
            end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int RES = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pwr,
  input logic           samp,
  input logic           busy,
  input logic           done,
  input logic [RES-1:0] trial,
  input logic [RES-1:0] result
);
  localparam logic [RES-1:0] TOP = {1'b1, {(RES-1){1'b0}}};

  a_r9_samp_busy: assert property (@(posedge clk) disable iff (!rst_n)
    samp |-> busy);

  a_r6_fall_conv: assert property (@(posedge clk) disable iff (!rst_n || !pwr)
    $fell(samp) |-> (busy && trial == TOP));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !samp));

  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  a_r11_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr |=> (!busy && !done));
endmodule

bind adc_seq adc_seq_chk #(.RES(RES)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr(pwr), .samp(samp), .busy(busy),
  .done(done), .trial(trial), .result(result)
);

// File: tb/sim_adc_seq.sv
`timescale 1ns/1ps
module sim_adc_seq;
  logic        clk = 0, rst_n = 0, pwr = 0, arm = 0, pulse_mode = 0;
  logic [1:0]  clk_sel = 0, trig_sel = 0;
  logic [2:0]  div_sel = 0, tmr_trig = 0;
  logic        trig_inv = 0, sw_start = 0;
  logic [3:0]  samp_code = 0, clk_en;
  logic        comp, samp, busy, done;
  logic [11:0] trial, result, ana = 0;
  int unsigned fc = 0;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;
  always_ff @(posedge clk) fc <= fc + 1;
  always_comb
    for (int i = 0; i < 4; i++) clk_en[i] = (fc % (i + 1)) == 0;
  assign comp = (ana >= trial);

  adc_seq u0 (.*);

  // {clk_sel, div_sel, samp_code, trig_sel, value}
  localparam int NV = 6;
  localparam logic [22:0] VEC [NV] = '{
    {2'd0, 3'd0, 4'd0, 2'd0, 12'hABC},
    {2'd1, 3'd1, 4'd1, 2'd1, 12'h000},
    {2'd2, 3'd2, 4'd0, 2'd2, 12'hFFF},
    {2'd3, 3'd7, 4'd2, 2'd3, 12'h555},
    {2'd0, 3'd4, 4'd3, 2'd0, 12'h800},
    {2'd0, 3'd0, 4'd9, 2'd1, 12'h7FF}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_trig(input int sel, input logic v);
    if (sel == 0) sw_start = v;
    else tmr_trig[sel-1] = v;
  endtask

  task automatic wait_samp(output bit seen);
    seen = 0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (samp) begin seen = 1; break; end
    end
  endtask

  task automatic count_run(output int hi, output int cv);
    hi = 0; cv = 0;
    while (samp && hi < 5000) begin hi++; @(negedge clk); end
    while (busy && !samp && cv < 5000) begin cv++; @(negedge clk); end
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit seen;
    int hi, cv, cnt, dn, cvc, len, per;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 samp", samp, 0); chk("R12 busy", busy, 0);
    chk("R12 done", done, 0); chk("R12 result", result, 0);
    chk("R12 trial", trial, 0);
    rst_n = 1; pwr = 1;
    repeat (3) @(negedge clk);

    // vector table: pulse mode, R1 R2 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      clk_sel = VEC[v][22:21]; div_sel = VEC[v][20:18];
      samp_code = VEC[v][17:14]; trig_sel = VEC[v][13:12];
      ana = VEC[v][11:0]; pulse_mode = 1; arm = 1; trig_inv = 0;
      len = (samp_code >= 8) ? 1024 : (4 << samp_code);
      per = (int'(clk_sel) + 1) * (int'(div_sel) + 1);
      repeat (3) @(negedge clk);
      set_trig(trig_sel, 1);
      wait_samp(seen);
      set_trig(trig_sel, 0);
      chk("R2 trigger starts", seen, 1);
      count_run(hi, cv);
      chk("R5 R1 sample length", hi, len * per);
      chk("R6 R1 conversion length", cv, 13 * per);
      chk("R8 done", done, 1);
      chk("R7 result", result, ana);
      @(negedge clk);
      chk("R8 done one cycle", done, 0);
    end

    // R4 direct mode, undivided clock
    clk_sel = 0; div_sel = 0; trig_sel = 0; pulse_mode = 0; ana = 12'h3A5;
    repeat (3) @(negedge clk);
    cnt = 0; dn = 0; cvc = 0;
    sw_start = 1;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (samp) cnt++;
      if (busy && !samp) cvc++;
      if (done) dn++;
      if (i == 20) sw_start = 0;
    end
    chk("R4 sample follows trigger", cnt, 20);
    chk("R6 direct conversion length", cvc, 13);
    chk("R8 direct done count", dn, 1);
    chk("R7 direct result", result, 12'h3A5);

    // R3 inverted trigger
    pulse_mode = 1; samp_code = 0; trig_sel = 1; arm = 0;
    tmr_trig[0] = 1; trig_inv = 1; ana = 12'h0F0;
    repeat (5) @(negedge clk);
    arm = 1;
    cnt = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (busy) cnt++; end
    chk("R3 high input idle when inverted", cnt, 0);
    tmr_trig[0] = 0;
    wait_samp(seen);
    chk("R3 falling input starts", seen, 1);
    count_run(hi, cv);
    chk("R3 result", result, 12'h0F0);
    arm = 0; tmr_trig[0] = 1;
    repeat (3) @(negedge clk);
    trig_inv = 0; tmr_trig[0] = 0;
    repeat (3) @(negedge clk);

    // R2 unselected input ignored
    arm = 1; trig_sel = 2; cnt = 0;
    sw_start = 1; tmr_trig[0] = 1;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (busy) cnt++; end
    sw_start = 0; tmr_trig[0] = 0;
    chk("R2 unselected ignored", cnt, 0);

    // R11 arm off
    trig_sel = 0; arm = 0; cnt = 0;
    sw_start = 1;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (busy) cnt++; end
    sw_start = 0;
    chk("R11 disarmed ignored", cnt, 0);

    // R11 power off
    arm = 1; pwr = 0; cnt = 0;
    sw_start = 1;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (busy) cnt++; end
    sw_start = 0;
    chk("R11 power off ignored", cnt, 0);
    pwr = 1;
    repeat (3) @(negedge clk);

    // R11 abort mid conversion
    ana = 12'h123;
    sw_start = 1;
    wait_samp(seen);
    sw_start = 0;
    while (samp) @(negedge clk);
    repeat (3) @(negedge clk);
    pwr = 0;
    @(negedge clk);
    chk("R11 abort busy", busy, 0);
    pwr = 1; dn = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (done) dn++; end
    chk("R11 abort no done", dn, 0);
    chk("R8 result kept", result, 12'h3A5 == 12'h3A5 ? 12'h0F0 : 0);

    // R10 trigger while busy ignored
    ana = 12'hC33; dn = 0; cnt = 0;
    sw_start = 1;
    wait_samp(seen);
    sw_start = 0;
    while (samp) @(negedge clk);
    repeat (4) @(negedge clk);
    sw_start = 1;
    repeat (3) @(negedge clk);
    sw_start = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (done) dn++;
      if (samp) cnt++;
    end
    chk("R10 single done", dn, 1);
    chk("R10 no new sample", cnt, 0);
    chk("R9 busy idle after", busy, 0);
    chk("R7 busy-test result", result, 12'hC33);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule